// File: doc/BRIEF.md
# Bayer Pattern Gain Offset Unit

This block sits in a raw-image capture path and scales each incoming sensor pixel by a gain chosen for its colour-filter site, then adds one shared offset. The result is clipped to the 10-bit pixel range. The colour of a pixel is not carried with the data. The block works it out from where the pixel sits in the mosaic: whether its line is odd or even, whether its column is odd or even, and which field the frame belongs to. A 16-bit pattern word maps each of these eight positions to one of four colour codes, and each code selects one of four gain registers.

A register-style write port programs the four gains, the offset and the pattern word. Writes land in staging registers. The staged values are copied into the working set only when the first pixel of a frame arrives, so a frame is always processed with one consistent configuration. The frame marker and the field-ID input are sampled on that same pixel.

Frame tracking is a two-state machine:
- `S_IDLE` is the state after reset. In it, pixels are dropped until a start-of-frame pixel arrives.
- The transition `start_frame` (a valid pixel with the frame marker set) moves the machine to `S_ACTIVE`.
- `S_ACTIVE` has one self-transition, `next_frame`, taken on every later start-of-frame pixel. That transition reloads the configuration and the field.

Top module: `bayer_gain_offset`

## Requirements
- R1: After reset, `out_valid` is 0. All four gains are 256, which is unity gain with 8 fractional bits. The offset is 0. The pattern word is 0x4E4E, which puts Gb then B on odd lines and R then Gr on even lines in both fields.
- R2: The colour codes are 0 = R/Ye, 1 = Gr/Cy, 2 = Gb/G and 3 = B/Mg. Code c selects the gain at write address c. The field-0 codes occupy pattern bits 7:0 and the field-1 codes occupy bits 15:8. Within each byte, the 2-bit fields from the low end are: odd line/odd pixel, odd line/even pixel, even line/odd pixel, even line/even pixel.
- R3: The first line of a frame and the first pixel of each line count as odd. A valid pixel with `pix_sol` set starts a new line, which flips the line parity. Every other accepted pixel flips the pixel parity.
- R4: The output value is ((pixel × gain) >> 8) + offset.
- R5: Any result above 1023 is output as 1023.
- R6: Writes use `cfg_addr` 0 to 3 for the gains (low 12 bits of `cfg_wdata`), address 4 for the offset (low 10 bits) and address 5 for the pattern (16 bits). A written value applies from the next start-of-frame pixel onward. That pixel itself uses the values written before its cycle.
- R7: Each accepted pixel produces `out_valid` high with its result exactly one clock later. `out_valid` is low in every other cycle.
- R8: In `S_IDLE`, a valid pixel without `pix_sof` produces no output.
- R9: `field_id` is sampled only on start-of-frame pixels. Changes to it within a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Input pixel valid |
| pix_data | input | 10 | Raw input pixel |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_sof | input | 1 | Pixel is the first of a frame |
| field_id | input | 1 | Field of the frame, sampled with the start-of-frame pixel |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 10 | Gain-corrected, offset, clipped pixel |

## Verification
Every result is due one clock edge after the input cycle that produced it, because the only register on the data path is the output stage. Configuration and field changes become visible only on the output of the next start-of-frame pixel, again one edge later. The bench drives each cycle's inputs on the falling edge. It lets its reference model predict that cycle's output from its own copy of the staged and working settings and its own parity counters. It compares `out_valid`, and when it is high also `out_data`, on the following falling edge, so each prediction is matched to exactly one rising edge.

// File: rtl/bgo_pkg.sv
package bgo_pkg;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_ACTIVE = 1'b1
    } frame_state_t;

    localparam int CFG_ADDR_W = 3;
    localparam int CFG_DATA_W = 16;
    localparam int PAT_W      = 16;
    localparam int NUM_COLOUR = 4;

    localparam logic [CFG_ADDR_W-1:0] ADDR_OFFSET  = 3'd4;
    localparam logic [CFG_ADDR_W-1:0] ADDR_PATTERN = 3'd5;

    // Gb,B on odd lines; R,Gr on even lines; same for both fields
    localparam logic [PAT_W-1:0] PAT_RESET = 16'h4E4E;

endpackage

// File: rtl/bgo_cfg_regs.sv
module bgo_cfg_regs
    import bgo_pkg::*;
#(
    parameter int GAIN_W = 12,
    parameter int OFS_W  = 10,
    parameter int FRAC   = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_wr,
    input  logic [CFG_ADDR_W-1:0]                cfg_addr,
    input  logic [CFG_DATA_W-1:0]                cfg_wdata,
    input  logic                                 frame_load,
    output logic [NUM_COLOUR-1:0][GAIN_W-1:0]    eff_gain,
    output logic [OFS_W-1:0]                     eff_offset,
    output logic [PAT_W-1:0]                     eff_pattern
);

    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << FRAC;

    logic [GAIN_W-1:0] stg_gain [NUM_COLOUR];
    logic [GAIN_W-1:0] act_gain [NUM_COLOUR];
    logic [OFS_W-1:0]  stg_offset, act_offset;
    logic [PAT_W-1:0]  stg_pattern, act_pattern;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_COLOUR; c++) begin
                stg_gain[c] <= GAIN_UNITY;
                act_gain[c] <= GAIN_UNITY;
            end
            stg_offset  <= '0;
            act_offset  <= '0;
            stg_pattern <= PAT_RESET;
            act_pattern <= PAT_RESET;
        end else begin
            if (frame_load) begin
                for (int c = 0; c < NUM_COLOUR; c++) act_gain[c] <= stg_gain[c];
                act_offset  <= stg_offset;
                act_pattern <= stg_pattern;
            end
            if (cfg_wr) begin
                for (int c = 0; c < NUM_COLOUR; c++)
                    if (cfg_addr == CFG_ADDR_W'(c)) stg_gain[c] <= cfg_wdata[GAIN_W-1:0];
                if (cfg_addr == ADDR_OFFSET)  stg_offset  <= cfg_wdata[OFS_W-1:0];
                if (cfg_addr == ADDR_PATTERN) stg_pattern <= cfg_wdata[PAT_W-1:0];
            end
        end
    end

    for (genvar c = 0; c < NUM_COLOUR; c++) begin : g_eff
        assign eff_gain[c] = frame_load ? stg_gain[c] : act_gain[c];
    end
    assign eff_offset  = frame_load ? stg_offset  : act_offset;
    assign eff_pattern = frame_load ? stg_pattern : act_pattern;

    // R6: working settings only move on a frame load
    p_hold_midframe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> ($stable(act_pattern) && $stable(act_offset) && $stable(act_gain[0])));

    p_load_takes_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (act_pattern == $past(stg_pattern)));

endmodule

// File: rtl/bgo_pattern_track.sv
module bgo_pattern_track
    import bgo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_sol,
    input  logic             field_id,
    input  logic [PAT_W-1:0] pattern,
    output logic             accept,
    output logic             frame_load,
    output logic [1:0]       colour
);

    frame_state_t state_q, state_d;
    logic line_odd_q, pix_odd_q, field_q;
    logic cur_line_odd, cur_pix_odd, cur_field;
    logic [1:0] site;
    logic [3:0] bitpos;

    assign frame_load = pix_valid && pix_sof;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and acceptance
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (frame_load) begin     // start_frame
                    state_d = S_ACTIVE;
                    accept  = 1'b1;
                end
            end
            S_ACTIVE: begin               // next_frame on frame_load
                accept = pix_valid;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        cur_field    = pix_sof ? field_id : field_q;
        cur_line_odd = pix_sof ? 1'b1 : (pix_sol ? ~line_odd_q : line_odd_q);
        cur_pix_odd  = (pix_sof || pix_sol) ? 1'b1 : ~pix_odd_q;
        site         = {~cur_line_odd, ~cur_pix_odd};
        bitpos       = {cur_field, site, 1'b0};
        colour       = pattern[bitpos +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_odd_q <= 1'b1;
            pix_odd_q  <= 1'b0;
            field_q    <= 1'b0;
        end else if (accept) begin
            line_odd_q <= cur_line_odd;
            pix_odd_q  <= cur_pix_odd;
            if (pix_sof) field_q <= field_id;
        end
    end

    // R3: within a line the pixel parity alternates
    p_pix_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pix_sof && !pix_sol) |=> (pix_odd_q != $past(pix_odd_q)));

    // R3: a line start always begins on an odd pixel
    p_line_start_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pix_sol) |=> pix_odd_q);

    // R9: field only changes on a frame start
    p_field_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(field_q));

    // R8: the machine never returns to idle
    p_no_return_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACTIVE) |=> (state_q == S_ACTIVE));

endmodule

// File: rtl/bgo_gain_mul.sv
module bgo_gain_mul #(
    parameter int PIX_W  = 10,
    parameter int GAIN_W = 12,
    parameter int OFS_W  = 10,
    parameter int FRAC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_data,
    input  logic [GAIN_W-1:0] gain,
    input  logic [OFS_W-1:0]  offset,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_data
);

    localparam int PROD_W = PIX_W + GAIN_W;
    localparam int SUM_W  = PROD_W - FRAC + 1;
    localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);
    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << FRAC;

    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;
    logic [PIX_W-1:0]  clipped;

    always_comb begin
        prod    = PROD_W'(in_data) * PROD_W'(gain);
        sum     = SUM_W'(prod >> FRAC) + SUM_W'(offset);
        clipped = (sum > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : sum[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= clipped;
        end
    end

    // R4: unity gain with no offset passes the pixel unchanged
    p_unity_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain == GAIN_UNITY && offset == '0) |=> (out_data == $past(in_data)));

    // R5: full-scale input with at least unity gain clips to full scale
    p_clip_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == '1 && gain >= GAIN_UNITY) |=> (out_data == '1));

endmodule

// File: rtl/bayer_gain_offset.sv
module bayer_gain_offset
    import bgo_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int GAIN_W = 12,
    parameter int OFS_W  = 10,
    parameter int FRAC   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_valid,
    input  logic [PIX_W-1:0]      pix_data,
    input  logic                  pix_sol,
    input  logic                  pix_sof,
    input  logic                  field_id,
    input  logic                  cfg_wr,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic                  out_valid,
    output logic [PIX_W-1:0]      out_data
);

    logic [NUM_COLOUR-1:0][GAIN_W-1:0] eff_gain;
    logic [OFS_W-1:0]                  eff_offset;
    logic [PAT_W-1:0]                  eff_pattern;
    logic                              accept, frame_load;
    logic [1:0]                        colour;

    bgo_pattern_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_sof    (pix_sof),
        .pix_sol    (pix_sol),
        .field_id   (field_id),
        .pattern    (eff_pattern),
        .accept     (accept),
        .frame_load (frame_load),
        .colour     (colour)
    );

    bgo_cfg_regs #(.GAIN_W(GAIN_W), .OFS_W(OFS_W), .FRAC(FRAC)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_load  (frame_load),
        .eff_gain    (eff_gain),
        .eff_offset  (eff_offset),
        .eff_pattern (eff_pattern)
    );

    bgo_gain_mul #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .FRAC(FRAC)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (accept),
        .in_data   (pix_data),
        .gain      (eff_gain[colour]),
        .offset    (eff_offset),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R7: no output without an input pixel one cycle before
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R8: a start-of-frame pixel is always answered
    p_sof_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sof) |=> out_valid);

endmodule

// File: tb/bayer_gain_offset_tb.sv
module bayer_gain_offset_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [9:0]  pix_data = '0;
    logic        pix_sol = 1'b0;
    logic        pix_sof = 1'b0;
    logic        field_id = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid;
    logic [9:0]  out_data;

    always #10 clk = ~clk;

    bayer_gain_offset u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_sol(pix_sol), .pix_sof(pix_sof), .field_id(field_id),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string req = "R1";

    // reference model state
    int sg [4];
    int ag [4];
    int so, ao, sp, ap;
    bit m_active, m_lodd, m_podd, m_fld;

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit v, input int d, input bit sof, input bit sol, input bit fid,
                       input bit wr, input int addr, input int wd);
        bit use_sof, acc, lo, po, f;
        int site, code, p, g, o, e;
        pix_valid = v; pix_data = 10'(d); pix_sof = sof; pix_sol = sol; field_id = fid;
        cfg_wr = wr; cfg_addr = 3'(addr); cfg_wdata = 16'(wd);
        use_sof = v && sof;
        acc = v && (m_active || sof);
        lo = sof ? 1'b1 : (sol ? !m_lodd : m_lodd);
        po = (sof || sol) ? 1'b1 : !m_podd;
        f  = sof ? fid : m_fld;
        p  = use_sof ? sp : ap;
        site = (lo ? 0 : 2) + (po ? 0 : 1);
        code = (p >> (f * 8 + site * 2)) & 3;
        g  = use_sof ? sg[code] : ag[code];
        o  = use_sof ? so : ao;
        e  = ((d * g) >> 8) + o;
        if (e > 1023) e = 1023;
        @(posedge clk);
        @(negedge clk);
        chk({"R7 ", req, " valid"}, int'(out_valid), int'(acc));
        if (acc) chk({"R4 ", req, " data"}, int'(out_data), e);
        if (use_sof) begin
            for (int c = 0; c < 4; c++) ag[c] = sg[c];
            ao = so; ap = sp; m_active = 1; m_fld = fid;
        end
        if (acc) begin m_lodd = lo; m_podd = po; end
        if (wr) begin
            if (addr < 4) sg[addr] = wd & 12'hFFF;
            else if (addr == 4) so = wd & 10'h3FF;
            else if (addr == 5) sp = wd & 16'hFFFF;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr_cfg(input int addr, input int wd);
        cyc(0, 0, 0, 0, 0, 1, addr, wd);
    endtask

    // frame of lines x ppl pixels; field flip mid-frame exercises R9
    task automatic frame(input int lines, input int ppl, input bit fid, input int base,
                         input int stp, input int gap);
        int d;
        d = base;
        for (int l = 0; l < lines; l++)
            for (int x = 0; x < ppl; x++) begin
                cyc(1, d % 1024, (l == 0 && x == 0), (x == 0 && l != 0),
                    (l == 0 && x == 0) ? fid : !fid, 0, 0, 0);
                d += stp;
                if (gap != 0 && (x % gap) == gap - 1) idle(1);
            end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin sg[c] = 256; ag[c] = 256; end
        so = 0; ao = 0; sp = 16'h4E4E; ap = 16'h4E4E;
        m_active = 0; m_lodd = 1; m_podd = 0; m_fld = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(out_valid), 0);

        req = "R8";   // pixels before any frame start are dropped
        for (int i = 0; i < 5; i++) cyc(1, 100 + i, 0, i == 2, 0, 0, 0, 0);

        req = "R1";   // defaults: unity gain, zero offset, reset pattern
        frame(3, 4, 0, 17, 37, 0);

        req = "R6";   // distinct gains written mid-frame must wait for next sof
        cyc(1, 10, 1, 0, 0, 0, 0, 0);
        wr_cfg(0, 512);
        cyc(1, 300, 0, 0, 1, 0, 0, 0);
        wr_cfg(1, 384);
        wr_cfg(2, 128);
        cyc(1, 301, 0, 1, 0, 1, 3, 1024);
        cyc(1, 302, 0, 0, 0, 1, 4, 5);
        cyc(1, 303, 0, 0, 0, 1, 5, 16'hE41B);
        cyc(1, 304, 0, 1, 0, 0, 0, 0);

        req = "R2";   // new settings, field 0 then field 1
        frame(2, 4, 0, 200, 13, 0);
        frame(2, 4, 1, 220, 11, 0);

        req = "R3";   // odd-length lines and valid gaps
        frame(3, 3, 1, 50, 29, 2);
        frame(4, 5, 0, 90, 7, 3);

        req = "R9";   // field_id toggling inside frames
        frame(2, 2, 1, 400, 3, 0);

        req = "R5";   // saturation through gain and through offset
        wr_cfg(0, 4095); wr_cfg(1, 4095); wr_cfg(2, 0); wr_cfg(3, 256);
        wr_cfg(4, 1000);
        frame(2, 4, 0, 1023, 1, 0);
        wr_cfg(4, 1023); wr_cfg(3, 0);
        frame(1, 4, 0, 0, 255, 0);
        wr_cfg(4, 0); wr_cfg(0, 1024);
        frame(2, 2, 1, 1023, 0, 1);

        req = "R6";   // write in the same cycle as sof stays staged one frame
        cyc(1, 500, 1, 0, 0, 1, 5, 16'h0000);
        cyc(1, 501, 0, 0, 0, 0, 0, 0);
        frame(2, 2, 0, 600, 1, 0);

        req = "R7";
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule